// File: doc/BRIEF.md
# Power-Fail Lockout and Time-Save Controller

This block guards a host register interface against a failing supply. It watches an active-low power-fail input, synchronizes it into the clock domain, and only accepts a failure once the input has stayed asserted for a full debounce window. An accepted failure raises a sticky interrupt, sets a status bit, and locks the host path. While the path is locked, write strobes are blocked and read data is forced to zero. A one-cycle snapshot strobe at the moment of lockout lets neighbouring logic copy the running time fields into save registers.

An optional extended delay sits between acceptance and lockout. It gives the host a last window in which to read or write. When the supply returns, the input must stay deasserted for another window of the same length before the path unlocks. All windows are counted in ticks of an external enable, so the wall-clock length is set by the tick rate together with the window parameters.

Top module: `pwrfail_guard`

## Requirements
- R1: After reset, `lockout`, `irq`, `pf_status` and `save_strobe` are all 0.
- R2: Suppose `pfail_n` goes low and stays low. After the `SYNC_STAGES`-flop synchronizer, one cycle is spent entering the debounce state, and then `DB_TICKS` ticks are counted. At the end of that count, `irq` and `pf_status` rise in the same cycle. With the delay disabled, `lockout` also rises in that cycle.
- R3: A low pulse on `pfail_n` lasting `DB_TICKS` cycles or less (ticks every cycle) has no effect on any output. A pulse of `DB_TICKS`+1 cycles is accepted.
- R4: The debounce count advances only in cycles where `tick` is 1. With `tick` held at 0, a low `pfail_n` never leads to acceptance.
- R5: If `dly_en` is 1 at acceptance, `lockout` rises `DLY_TICKS` ticks after `irq`. During that delay, `pf_status` is 1 and host accesses still pass. Once started, the delay always runs to completion.
- R6: While `lockout` is 1, `host_wr_o` is 0 and `host_rd_data_o` is 0. Otherwise, both outputs equal their host-side inputs.
- R7: `save_strobe` is a single-cycle pulse in the cycle `lockout` first rises after an accepted failure, and only if `tsave_en` is 1 at that point. No pulse occurs when `tsave_en` is 0.
- R8: After `pfail_n` returns high, `lockout` falls once it has stayed high for the same debounce length as in R2. If `pfail_n` falls again inside that window, the block returns to locked without ending lockout and without a new `save_strobe`.
- R9: `irq` stays set until `irq_clr` is applied while `pf_status` is 0. It then clears one cycle later. An `irq_clr` applied while `pf_status` is 1 is ignored.
- R10: `pf_status` is 1 from acceptance until unlock, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pfail_n | input | 1 | Asynchronous power-fail input, low means failing |
| tick | input | 1 | Time-base enable for all windows |
| dly_en | input | 1 | Insert the extended pre-lockout delay |
| tsave_en | input | 1 | Allow the time-save strobe |
| irq_clr | input | 1 | Clear request for the interrupt flag |
| host_wr_i | input | 1 | Host write strobe toward the register file |
| host_rd_data_i | input | DATA_W | Read data from the register file |
| host_wr_o | output | 1 | Gated write strobe |
| host_rd_data_o | output | DATA_W | Gated read data |
| lockout | output | 1 | Host path locked |
| save_strobe | output | 1 | One-cycle time snapshot pulse |
| irq | output | 1 | Sticky power-fail interrupt |
| pf_status | output | 1 | Power-fail currently in effect |

## Verification
The hardest situation to reach is the supply dropping again while the recovery window is still running. The stimulus has to raise `pfail_n` and then lower it a precise number of cycles later, so that the re-fall lands inside the recovery count. The bench then confirms that no unlock edge and no second snapshot pulse appear. The boundary between rejection and acceptance is reached with pulses of exactly `DB_TICKS` and `DB_TICKS`+1 cycles. The tick gating is shown by holding `tick` low through a long failure and then releasing it.

// File: rtl/pf_pkg.sv
// Package: shared state encoding for the power-fail controller.
package pf_pkg;
    typedef enum logic [2:0] {
        PF_NORMAL   = 3'd0,
        PF_DB_FAIL  = 3'd1,
        PF_DELAY    = 3'd2,
        PF_LOCKED   = 3'd3,
        PF_DB_RECOV = 3'd4
    } pf_state_e;
endpackage

// File: rtl/pf_sync.sv
// Module: pf_sync
// Brings the asynchronous active-low power-fail pin into the clock domain.
// Assumes the pin idles high; every stage resets to 1.
module pf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Shift one synchronizer stage.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[i] <= 1'b1;
                else if (i == 0)
                    chain[i] <= async_n;
                else
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/pf_window.sv
// Module: pf_window
// Tick counter shared by the debounce and delay windows. It signals expiry
// on the tick that completes `limit` ticks since the last restart.
// Assumes limit >= 1 and that the caller restarts it on every state change.
module pf_window #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    // Count ticks; clear on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    // Expiry on the tick that reaches the limit.
    always_comb expire = tick && (cnt == limit - 1'b1);
endmodule

// File: rtl/pf_ctrl.sv
// Module: pf_ctrl
// Sequencer: normal -> fail debounce -> optional delay -> locked ->
// recovery debounce -> normal. Owns the interrupt flag and the save strobe.
// Assumes fail_s is already synchronous and expire comes from pf_window.
module pf_ctrl
    import pf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fail_s,
    input  logic expire,
    input  logic dly_en,
    input  logic tsave_en,
    input  logic irq_clr,
    output logic restart,
    output logic use_dly,
    output logic locked,
    output logic status,
    output logic save_strobe,
    output logic irq
);
    pf_state_e st, nxt;
    logic      accept;

    // Next-state selection.
    always_comb begin
        nxt = st;
        unique case (st)
            PF_NORMAL:   if (fail_s) nxt = PF_DB_FAIL;
            PF_DB_FAIL:  if (!fail_s) nxt = PF_NORMAL;
                         else if (expire) nxt = dly_en ? PF_DELAY : PF_LOCKED;
            PF_DELAY:    if (expire) nxt = PF_LOCKED;
            PF_LOCKED:   if (!fail_s) nxt = PF_DB_RECOV;
            PF_DB_RECOV: if (fail_s) nxt = PF_LOCKED;
                         else if (expire) nxt = PF_NORMAL;
            default:     nxt = PF_NORMAL;
        endcase
    end

    // Derived controls for the window counter.
    always_comb begin
        accept  = (st == PF_DB_FAIL) && fail_s && expire;
        restart = (nxt != st);
        use_dly = (st == PF_DELAY);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= PF_NORMAL;
        else        st <= nxt;
    end

    // Snapshot pulse only on first entry to locked after a failure.
    always_ff @(posedge clk) begin
        if (!rst_n)
            save_strobe <= 1'b0;
        else
            save_strobe <= tsave_en && (nxt == PF_LOCKED) &&
                           ((st == PF_DB_FAIL) || (st == PF_DELAY));
    end

    // Sticky interrupt; clear honoured only outside a failure.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (accept)
            irq <= 1'b1;
        else if (irq_clr && !status)
            irq <= 1'b0;
    end

    // Output decode from the state register.
    always_comb begin
        locked = (st == PF_LOCKED) || (st == PF_DB_RECOV);
        status = locked || (st == PF_DELAY);
    end
endmodule

// File: rtl/pf_host_gate.sv
// Module: pf_host_gate
// Blocks host writes and zeroes read data while the lock is active.
// Purely combinational; assumes lock is a registered signal.
module pf_host_gate #(
    parameter int DATA_W = 8
) (
    input  logic              lock,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] rd_i,
    output logic              wr_o,
    output logic [DATA_W-1:0] rd_o
);
    // Gate both directions with the lock.
    always_comb begin
        wr_o = wr_i && !lock;
        rd_o = lock ? '0 : rd_i;
    end
endmodule

// File: rtl/pwrfail_guard.sv
// Module: pwrfail_guard (top)
// Power-fail lockout and time-save controller. All windows are counted in
// ticks of `tick`. Assumes DB_TICKS and DLY_TICKS are at least 1.
module pwrfail_guard #(
    parameter int DB_TICKS    = 32,
    parameter int DLY_TICKS   = 480,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pfail_n,
    input  logic              tick,
    input  logic              dly_en,
    input  logic              tsave_en,
    input  logic              irq_clr,
    input  logic              host_wr_i,
    input  logic [DATA_W-1:0] host_rd_data_i,
    output logic              host_wr_o,
    output logic [DATA_W-1:0] host_rd_data_o,
    output logic              lockout,
    output logic              save_strobe,
    output logic              irq,
    output logic              pf_status
);
    localparam int MAX_T = (DB_TICKS > DLY_TICKS) ? DB_TICKS : DLY_TICKS;
    localparam int CNT_W = $clog2(MAX_T + 1);

    logic             sync_n, restart, use_dly, expire;
    logic [CNT_W-1:0] limit;

    pf_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_n(pfail_n), .sync_n(sync_n)
    );

    // Window length for the current state.
    always_comb limit = use_dly ? CNT_W'(DLY_TICKS) : CNT_W'(DB_TICKS);

    pf_window #(.CNT_W(CNT_W)) win_i (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
        .limit(limit), .expire(expire)
    );

    pf_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n), .fail_s(!sync_n), .expire(expire),
        .dly_en(dly_en), .tsave_en(tsave_en), .irq_clr(irq_clr),
        .restart(restart), .use_dly(use_dly), .locked(lockout),
        .status(pf_status), .save_strobe(save_strobe), .irq(irq)
    );

    pf_host_gate #(.DATA_W(DATA_W)) gate_i (
        .lock(lockout), .wr_i(host_wr_i), .rd_i(host_rd_data_i),
        .wr_o(host_wr_o), .rd_o(host_rd_data_o)
    );
endmodule

// File: rtl/pwrfail_guard_chk.sv
// Module: pwrfail_guard_chk
// Port-level properties of pwrfail_guard, attached by bind.
module pwrfail_guard_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tsave_en,
    input logic              irq_clr,
    input logic              host_wr_o,
    input logic [DATA_W-1:0] host_rd_data_o,
    input logic              lockout,
    input logic              save_strobe,
    input logic              irq,
    input logic              pf_status
);
    p_wr_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |-> !host_wr_o);
    p_rd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |-> (host_rd_data_o == '0));
    p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        save_strobe |=> !save_strobe);
    p_strobe_at_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        save_strobe |-> $rose(lockout));
    p_strobe_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        save_strobe |-> $past(tsave_en));
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
    p_clr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && pf_status) |=> irq);
    p_lock_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |-> pf_status);
    p_status_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_status) |-> irq);
endmodule

bind pwrfail_guard pwrfail_guard_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .tsave_en(tsave_en), .irq_clr(irq_clr),
    .host_wr_o(host_wr_o), .host_rd_data_o(host_rd_data_o),
    .lockout(lockout), .save_strobe(save_strobe), .irq(irq),
    .pf_status(pf_status)
);

// File: tb/pwrfail_guard_tb_top.sv
// Scoreboard bench: driver pushes expected output edges with their cycle,
// a monitor pops and compares them as edges appear.
module pwrfail_guard_tb_top;
    localparam int DB  = 4;
    localparam int DLY = 10;
    localparam int LAT = 3 + DB;   // sync (2) + entry (1) + window

    localparam int EV_IRQ_R  = 0;
    localparam int EV_LOCK_R = 1;
    localparam int EV_SAVE   = 2;
    localparam int EV_LOCK_F = 3;
    localparam int EV_IRQ_F  = 4;

    logic       clk = 1'b0;
    logic       rst_n, pfail_n, tick, dly_en, tsave_en, irq_clr, host_wr_i;
    logic [7:0] host_rd_data_i, host_rd_data_o;
    logic       host_wr_o, lockout, save_strobe, irq, pf_status;

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;
    logic  p_irq = 1'b0, p_lock = 1'b0;
    int    q_kind[$];
    int    q_cyc[$];
    string q_req[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwrfail_guard #(.DB_TICKS(DB), .DLY_TICKS(DLY), .DATA_W(8), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .pfail_n(pfail_n), .tick(tick),
        .dly_en(dly_en), .tsave_en(tsave_en), .irq_clr(irq_clr),
        .host_wr_i(host_wr_i), .host_rd_data_i(host_rd_data_i),
        .host_wr_o(host_wr_o), .host_rd_data_o(host_rd_data_o),
        .lockout(lockout), .save_strobe(save_strobe), .irq(irq),
        .pf_status(pf_status)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push(input int kind, input int at, input string req);
        q_kind.push_back(kind);
        q_cyc.push_back(at);
        q_req.push_back(req);
    endtask

    task automatic observe(input int kind);
        int    ek, ec;
        string er;
        checks++;
        if (q_kind.size() == 0) begin
            errors++;
            $display("FAIL unexpected event: actual kind %0d at %0d expected none", kind, cyc);
        end else begin
            ek = q_kind.pop_front();
            ec = q_cyc.pop_front();
            er = q_req.pop_front();
            if (ek != kind || ec != cyc) begin
                errors++;
                $display("FAIL %s: actual kind %0d cycle %0d expected kind %0d cycle %0d",
                         er, kind, cyc, ek, ec);
            end
        end
    endtask

    // Monitor: turn output edges into events and compare them.
    always @(negedge clk) begin
        if (mon_on) begin
            if (irq && !p_irq)      observe(EV_IRQ_R);
            if (lockout && !p_lock) observe(EV_LOCK_R);
            if (save_strobe)        observe(EV_SAVE);
            if (!lockout && p_lock) observe(EV_LOCK_F);
            if (!irq && p_irq)      observe(EV_IRQ_F);
        end
        p_irq  = irq;
        p_lock = lockout;
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_irq(input string req);
        irq_clr = 1'b1;
        push(EV_IRQ_F, cyc + 1, req);
        wait_n(1);
        irq_clr = 1'b0;
        wait_n(2);
    endtask

    task automatic recover(input string req);
        pfail_n = 1'b1;
        push(EV_LOCK_F, cyc + LAT, req);
        wait_n(LAT + 3);
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        int t0;
        rst_n = 1'b0; pfail_n = 1'b1; tick = 1'b1; dly_en = 1'b0; tsave_en = 1'b1;
        irq_clr = 1'b0; host_wr_i = 1'b1; host_rd_data_i = 8'hA5;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // R1 reset state
        check(!lockout && !irq && !pf_status && !save_strobe, "R1", {lockout, irq, pf_status, save_strobe}, 0);
        // R6 pass-through when unlocked
        check(host_wr_o == 1'b1, "R6", host_wr_o, 1);
        check(host_rd_data_o == 8'hA5, "R6", host_rd_data_o, 8'hA5);
        mon_on = 1'b1;

        // R2/R7: steady failure, no delay, save enabled
        t0 = cyc; pfail_n = 1'b0;
        push(EV_IRQ_R, t0 + LAT, "R2");
        push(EV_LOCK_R, t0 + LAT, "R2");
        push(EV_SAVE, t0 + LAT, "R7");
        wait_n(LAT + 3);
        check(pf_status == 1'b1, "R10", pf_status, 1);
        check(host_wr_o == 1'b0, "R6", host_wr_o, 0);
        check(host_rd_data_o == 8'h00, "R6", host_rd_data_o, 0);
        irq_clr = 1'b1; wait_n(1); irq_clr = 1'b0; wait_n(2);
        check(irq == 1'b1, "R9", irq, 1);

        // R8: re-fall inside the recovery window keeps the lock
        pfail_n = 1'b1; wait_n(2); pfail_n = 1'b0;
        wait_n(10);
        check(lockout == 1'b1, "R8", lockout, 1);
        recover("R8");
        check(pf_status == 1'b0, "R10", pf_status, 0);
        check(host_wr_o == 1'b1 && host_rd_data_o == 8'hA5, "R6", host_rd_data_o, 8'hA5);
        clear_irq("R9");

        // R3: pulse of DB cycles is rejected
        pfail_n = 1'b0; wait_n(DB); pfail_n = 1'b1;
        wait_n(12);
        check(lockout == 1'b0 && irq == 1'b0, "R3", {lockout, irq}, 0);

        // R3/R7: pulse of DB+1 cycles accepted, no strobe with save disabled
        tsave_en = 1'b0;
        t0 = cyc; pfail_n = 1'b0;
        push(EV_IRQ_R, t0 + LAT, "R3");
        push(EV_LOCK_R, t0 + LAT, "R3");
        wait_n(DB + 1);
        pfail_n = 1'b1;
        push(EV_LOCK_F, t0 + DB + 1 + LAT, "R8");
        wait_n(12);
        check(irq == 1'b1, "R9", irq, 1);
        clear_irq("R9");

        // R5: extended delay before lockout
        tsave_en = 1'b1; dly_en = 1'b1;
        t0 = cyc; pfail_n = 1'b0;
        push(EV_IRQ_R, t0 + LAT, "R5");
        push(EV_LOCK_R, t0 + LAT + DLY, "R5");
        push(EV_SAVE, t0 + LAT + DLY, "R7");
        wait_n(LAT + 2);
        check(pf_status == 1'b1 && lockout == 1'b0, "R5", {pf_status, lockout}, 2);
        check(host_wr_o == 1'b1, "R5", host_wr_o, 1);
        wait_n(DLY + 2);
        dly_en = 1'b0;
        recover("R8");
        clear_irq("R9");

        // R4: no ticks, no acceptance
        tick = 1'b0;
        pfail_n = 1'b0;
        wait_n(20);
        check(lockout == 1'b0 && pf_status == 1'b0 && irq == 1'b0, "R4", {lockout, pf_status, irq}, 0);
        t0 = cyc; tick = 1'b1;
        push(EV_IRQ_R, t0 + DB, "R4");
        push(EV_LOCK_R, t0 + DB, "R4");
        push(EV_SAVE, t0 + DB, "R7");
        wait_n(DB + 4);
        recover("R8");
        clear_irq("R9");

        wait_n(4);
        check(q_kind.size() == 0, "R2", q_kind.size(), 0);
        done = 1'b1;
        finish_run();
    end
endmodule